// File: doc/BRIEF.md
# Two-Tier Interrupt Controller

This block holds the interrupt gating and control state of a small 8-bit microcontroller core. Each interrupt source has a sticky flag bit and an enable bit. A flag sets whenever its event occurs, whatever the state of any enable. Three core sources feed the CPU request through the global enable alone: a timer overflow pulse, a rising edge on an asynchronous external pin, and a change on a small asynchronous input port. Up to sixteen peripheral sources (twelve by default) must first pass a peripheral-group enable and then the global enable.

Software reaches the state through register-style write strobes. An 8-bit core control register holds the global enable, the group enable, the three core enables and the three core flags. Two 8-bit banks hold the peripheral enables and flags. When the CPU takes the interrupt, an acknowledge pulse clears the global enable. A return-from-interrupt pulse sets it again. Flags are cleared only by software, so a flag left set causes an immediate re-entry. A wake-up output reports any enabled pending source without regard to the global enable, so a sleeping core can resume.

Top module: `irq_two_tier`

## Requirements
- R1: A source flag sets on the clock edge after its event is seen, whatever the state of its own enable, the group enable and the global enable.
- R2: The core control register reads as {global enable [7], group enable [6], timer enable [5], pin enable [4], port enable [3], timer flag [2], pin flag [1], port flag [0]}. After reset it and both peripheral register banks read 0, and irq_o and wake_o are low.
- R3: irq_o is high exactly when the global enable is set and at least one source has both its flag and its enable set, subject to R4.
- R4: The group enable gates only the peripheral sources. Core sources reach irq_o with the group enable clear.
- R5: vec_take_i clears the global enable on the next edge. vec_addr_o reads 14'h0004.
- R6: reti_i sets the global enable on the next edge. Same-cycle priority is vec_take_i over reti_i over a core register write of bit 7.
- R7: Taking the interrupt leaves every flag unchanged. A flag still set raises irq_o again as soon as the global enable returns.
- R8: wake_o is high exactly when some enabled source is pending (peripherals also need the group enable), regardless of the global enable.
- R9: A write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. An event on the same cycle as such a clear leaves the flag set.
- R10: A rising edge on ext_pin_i, applied between two clock edges, sets the pin flag on the third edge after it. A held high level or a falling edge does not set it.
- R11: The port flag sets (third edge after a change) while the synchronized port value differs from a snapshot. port_rd_i loads the snapshot with the synchronized value.
- R12: per_bank_i = 0 selects peripheral sources 0 to 7 and 1 selects sources 8 to 15. An enable write replaces the bank's 8 enables, and a flag write clears the bits written 0. Bits for sources at or above NUM_PERIPH always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf_i | input | 1 | Timer overflow event pulse (synchronous) |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| port_i | input | PORT_W | Asynchronous watched port inputs |
| port_rd_i | input | 1 | Port read strobe, loads the change snapshot |
| per_evt_i | input | NUM_PERIPH | Peripheral event pulses |
| core_wr_i | input | 1 | Core control register write strobe |
| core_wdata_i | input | 8 | Core control register write data |
| per_bank_i | input | 1 | Peripheral bank select |
| per_en_wr_i | input | 1 | Peripheral enable bank write strobe |
| per_flg_wr_i | input | 1 | Peripheral flag bank write (clear) strobe |
| per_wdata_i | input | 8 | Peripheral bank write data |
| vec_take_i | input | 1 | CPU has taken the interrupt |
| reti_i | input | 1 | Return-from-interrupt pulse |
| core_q_o | output | 8 | Core control register contents |
| per_en_o | output | 16 | Peripheral enables, both banks |
| per_flag_o | output | 16 | Peripheral flags, both banks |
| irq_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | Wake-from-sleep request |
| vec_addr_o | output | 14 | Interrupt vector address |

## Verification
The properties take the synchronous inputs (timer pulse, peripheral events, strobes, acknowledge and return pulses) to be clean at each rising edge. They look at the pin and port inputs only through the flags those inputs produce. The bench changes every input just after a falling edge and holds it for a full cycle. It holds the pin and port steady for several cycles around each change, so the synchronizer never sees a value change within a setup window. Between sweep steps all state is cleared through the write strobes, so each step starts from a known register image.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CORE_W = 8;
    localparam int BANK_W = 8;
    localparam int NBANK  = 2;
    localparam int PREG_W = NBANK * BANK_W;

    // core control register bit positions
    localparam int B_GIE  = 7;
    localparam int B_PEIE = 6;
    localparam int B_TEN  = 5;
    localparam int B_PEN  = 3;
    localparam int B_TF   = 2;
    localparam int B_PF   = 0;

    // core source index inside the 3-bit enable/flag groups
    localparam int SRC_PORT = 0;
    localparam int SRC_PIN  = 1;
    localparam int SRC_TMR  = 2;

    typedef struct packed {
        logic       gie;
        logic       peie;
        logic [2:0] en;
        logic [2:0] flag;
    } core_reg_t;

endpackage

// File: rtl/irq_front.sv
module irq_front #(
    parameter int PORT_W = 4,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin_i,
    input  logic [PORT_W-1:0] port_i,
    input  logic              port_rd_i,
    output logic              pin_evt_o,
    output logic              port_evt_o
);

    typedef struct packed {
        logic [SYNC-1:0]             pin_sync;
        logic                        pin_prev;
        logic [SYNC-1:0][PORT_W-1:0] port_sync;
        logic [PORT_W-1:0]           snap;
    } front_t;

    front_t q, d;

    always_comb begin
        d           = q;
        d.pin_sync  = {q.pin_sync[SYNC-2:0], ext_pin_i};
        d.pin_prev  = q.pin_sync[SYNC-1];
        d.port_sync = {q.port_sync[SYNC-2:0], port_i};
        if (port_rd_i) begin
            d.snap = q.port_sync[SYNC-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pin_evt_o  = q.pin_sync[SYNC-1] & ~q.pin_prev;
    assign port_evt_o = (q.port_sync[SYNC-1] != q.snap);

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int NUM_PERIPH = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            core_evt_i,
    input  logic [NUM_PERIPH-1:0] per_evt_i,
    input  logic                  core_wr_i,
    input  logic [CORE_W-1:0]     core_wdata_i,
    input  logic                  per_bank_i,
    input  logic                  per_en_wr_i,
    input  logic                  per_flg_wr_i,
    input  logic [BANK_W-1:0]     per_wdata_i,
    input  logic                  vec_take_i,
    input  logic                  reti_i,
    output core_reg_t             core_o,
    output logic [PREG_W-1:0]     per_en_o,
    output logic [PREG_W-1:0]     per_flag_o
);

    function automatic logic [PREG_W-1:0] valid_mask();
        logic [PREG_W-1:0] m;
        for (int i = 0; i < PREG_W; i++) begin
            m[i] = (i < NUM_PERIPH);
        end
        return m;
    endfunction

    localparam logic [PREG_W-1:0] VALID = valid_mask();

    typedef struct packed {
        core_reg_t         core;
        logic [PREG_W-1:0] pen;
        logic [PREG_W-1:0] pflag;
    } regs_t;

    regs_t             q, d;
    logic [PREG_W-1:0] per_clr;
    logic [PREG_W-1:0] evt_w;

    assign evt_w = PREG_W'(per_evt_i);

    always_comb begin
        d       = q;
        per_clr = '0;

        if (core_wr_i) begin
            d.core.peie = core_wdata_i[B_PEIE];
            d.core.en   = core_wdata_i[B_TEN:B_PEN];
        end
        // event set wins over software clear
        d.core.flag = core_evt_i
                    | (q.core.flag & ~({3{core_wr_i}} & ~core_wdata_i[B_TF:B_PF]));

        if (vec_take_i) begin
            d.core.gie = 1'b0;
        end else if (reti_i) begin
            d.core.gie = 1'b1;
        end else if (core_wr_i) begin
            d.core.gie = core_wdata_i[B_GIE];
        end

        for (int b = 0; b < NBANK; b++) begin
            if (per_bank_i == 1'(b)) begin
                if (per_en_wr_i) begin
                    d.pen[b*BANK_W +: BANK_W] = per_wdata_i;
                end
                if (per_flg_wr_i) begin
                    per_clr[b*BANK_W +: BANK_W] = ~per_wdata_i;
                end
            end
        end
        d.pen   = d.pen & VALID;
        d.pflag = (evt_w | (q.pflag & ~per_clr)) & VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign core_o     = q.core;
    assign per_en_o   = q.pen;
    assign per_flag_o = q.pflag;

endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int NCORE = 3,
    parameter int NPER  = 16
) (
    input  logic             gie_i,
    input  logic             peie_i,
    input  logic [NCORE-1:0] core_en_i,
    input  logic [NCORE-1:0] core_flag_i,
    input  logic [NPER-1:0]  per_en_i,
    input  logic [NPER-1:0]  per_flag_i,
    output logic             irq_o,
    output logic             wake_o
);

    logic [NPER-1:0] per_hit;
    logic            core_any;
    logic            per_any;

    genvar g;
    generate
        for (g = 0; g < NPER; g++) begin : g_per
            assign per_hit[g] = per_en_i[g] & per_flag_i[g];
        end
    endgenerate

    assign core_any = |(core_en_i & core_flag_i);
    assign per_any  = peie_i & (|per_hit);
    assign wake_o   = core_any | per_any;
    assign irq_o    = gie_i & wake_o;

endmodule

// File: rtl/irq_two_tier.sv
module irq_two_tier
    import irq_pkg::*;
#(
    parameter int          NUM_PERIPH = 12,
    parameter int          PORT_W     = 4,
    parameter int          SYNC       = 2,
    parameter logic [13:0] VEC_ADDR   = 14'h0004
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tmr_ovf_i,
    input  logic                  ext_pin_i,
    input  logic [PORT_W-1:0]     port_i,
    input  logic                  port_rd_i,
    input  logic [NUM_PERIPH-1:0] per_evt_i,
    input  logic                  core_wr_i,
    input  logic [7:0]            core_wdata_i,
    input  logic                  per_bank_i,
    input  logic                  per_en_wr_i,
    input  logic                  per_flg_wr_i,
    input  logic [7:0]            per_wdata_i,
    input  logic                  vec_take_i,
    input  logic                  reti_i,
    output logic [7:0]            core_q_o,
    output logic [15:0]           per_en_o,
    output logic [15:0]           per_flag_o,
    output logic                  irq_o,
    output logic                  wake_o,
    output logic [13:0]           vec_addr_o
);

    logic      pin_evt;
    logic      port_evt;
    logic [2:0] core_evt;
    core_reg_t core;

    irq_front #(.PORT_W(PORT_W), .SYNC(SYNC)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin_i  (ext_pin_i),
        .port_i     (port_i),
        .port_rd_i  (port_rd_i),
        .pin_evt_o  (pin_evt),
        .port_evt_o (port_evt)
    );

    always_comb begin
        core_evt           = '0;
        core_evt[SRC_TMR]  = tmr_ovf_i;
        core_evt[SRC_PIN]  = pin_evt;
        core_evt[SRC_PORT] = port_evt;
    end

    irq_regs #(.NUM_PERIPH(NUM_PERIPH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_evt_i   (core_evt),
        .per_evt_i    (per_evt_i),
        .core_wr_i    (core_wr_i),
        .core_wdata_i (core_wdata_i),
        .per_bank_i   (per_bank_i),
        .per_en_wr_i  (per_en_wr_i),
        .per_flg_wr_i (per_flg_wr_i),
        .per_wdata_i  (per_wdata_i),
        .vec_take_i   (vec_take_i),
        .reti_i       (reti_i),
        .core_o       (core),
        .per_en_o     (per_en_o),
        .per_flag_o   (per_flag_o)
    );

    irq_gate #(.NCORE(3), .NPER(PREG_W)) u_gate (
        .gie_i       (core.gie),
        .peie_i      (core.peie),
        .core_en_i   (core.en),
        .core_flag_i (core.flag),
        .per_en_i    (per_en_o),
        .per_flag_i  (per_flag_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    assign core_q_o   = core;
    assign vec_addr_o = VEC_ADDR;

endmodule

// File: rtl/irq_two_tier_chk.sv
module irq_two_tier_chk #(
    parameter int NUM_PERIPH = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tmr_ovf_i,
    input logic [NUM_PERIPH-1:0] per_evt_i,
    input logic                  core_wr_i,
    input logic                  vec_take_i,
    input logic                  reti_i,
    input logic [7:0]            core_q_o,
    input logic [15:0]           per_flag_o,
    input logic                  irq_o,
    input logic                  wake_o
);

    a_r3_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> core_q_o[7]);

    a_r4_core_bypasses_group: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q_o[7] && (|(core_q_o[5:3] & core_q_o[2:0]))) |-> irq_o);

    a_r8_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

    a_r5_take_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take_i |=> !core_q_o[7]);

    a_r6_reti_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !vec_take_i) |=> core_q_o[7]);

    a_r7_take_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_take_i && !core_wr_i) |=>
            ((core_q_o[2:0] & $past(core_q_o[2:0])) == $past(core_q_o[2:0])));

    a_r9_tmr_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf_i |=> core_q_o[2]);

    a_r1_per_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|per_evt_i) |=>
            ((per_flag_o & 16'($past(per_evt_i))) == 16'($past(per_evt_i))));

endmodule

bind irq_two_tier irq_two_tier_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_ovf_i  (tmr_ovf_i),
    .per_evt_i  (per_evt_i),
    .core_wr_i  (core_wr_i),
    .vec_take_i (vec_take_i),
    .reti_i     (reti_i),
    .core_q_o   (core_q_o),
    .per_flag_o (per_flag_o),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
);

// File: tb/irq_two_tier_bench.sv
`timescale 1ns/1ps
module irq_two_tier_bench;

    localparam int NP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tmr_ovf_i = 1'b0;
    logic          ext_pin_i = 1'b0;
    logic [3:0]    port_i = '0;
    logic          port_rd_i = 1'b0;
    logic [NP-1:0] per_evt_i = '0;
    logic          core_wr_i = 1'b0;
    logic [7:0]    core_wdata_i = '0;
    logic          per_bank_i = 1'b0;
    logic          per_en_wr_i = 1'b0;
    logic          per_flg_wr_i = 1'b0;
    logic [7:0]    per_wdata_i = '0;
    logic          vec_take_i = 1'b0;
    logic          reti_i = 1'b0;
    logic [7:0]    core_q_o;
    logic [15:0]   per_en_o;
    logic [15:0]   per_flag_o;
    logic          irq_o;
    logic          wake_o;
    logic [13:0]   vec_addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_two_tier #(.NUM_PERIPH(NP)) u_irq_two_tier (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic core_write(input logic [7:0] v);
        core_wr_i = 1'b1; core_wdata_i = v;
        cyc();
        core_wr_i = 1'b0;
    endtask

    task automatic pen_write(input logic b, input logic [7:0] v);
        per_bank_i = b; per_en_wr_i = 1'b1; per_wdata_i = v;
        cyc();
        per_en_wr_i = 1'b0;
    endtask

    task automatic pflg_write(input logic b, input logic [7:0] v);
        per_bank_i = b; per_flg_wr_i = 1'b1; per_wdata_i = v;
        cyc();
        per_flg_wr_i = 1'b0;
    endtask

    task automatic clear_all();
        core_write(8'h00);
        pen_write(1'b0, 8'h00);
        pen_write(1'b1, 8'h00);
        pflg_write(1'b0, 8'h00);
        pflg_write(1'b1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R2 reset image, R5 vector value
        check("R2 core reg", 32'(core_q_o), 32'h0);
        check("R2 per en", 32'(per_en_o), 32'h0);
        check("R2 per flag", 32'(per_flag_o), 32'h0);
        check("R2 irq", 32'(irq_o), 32'h0);
        check("R2 wake", 32'(wake_o), 32'h0);
        check("R5 vector", 32'(vec_addr_o), 32'h0004);

        // sweep R1 R3 R4 R8 over gie, peie, timer en/flag, periph en/flag, source 3 or 9
        for (int k = 0; k < 128; k++) begin
            logic gie, peie, ten, tf, pe, pf;
            int src;
            logic exp_wake;
            gie = k[0]; peie = k[1]; ten = k[2]; tf = k[3]; pe = k[4]; pf = k[5];
            src = k[6] ? 9 : 3;
            clear_all();
            tmr_ovf_i = tf;
            per_evt_i = pf ? (NP'(1) << src) : '0;
            cyc();
            tmr_ovf_i = 1'b0; per_evt_i = '0;
            pen_write(1'(src / 8), 8'(pe) << (src % 8));
            core_write({gie, peie, ten, 2'b00, 3'b111});
            exp_wake = (ten & tf) | (peie & pe & pf);
            check("R1 core image", 32'(core_q_o), 32'({gie, peie, ten, 2'b00, tf, 2'b00}));
            check("R1 per flags", 32'(per_flag_o), pf ? (32'h1 << src) : 32'h0);
            check("R3 irq", 32'(irq_o), 32'(gie & exp_wake));
            check("R8 wake", 32'(wake_o), 32'(exp_wake));
        end

        // R5 R7 R6: take, re-entry, priorities
        clear_all();
        tmr_ovf_i = 1'b1; cyc(); tmr_ovf_i = 1'b0;
        core_write(8'hA7);
        check("R3 irq armed", 32'(irq_o), 32'h1);
        vec_take_i = 1'b1; cyc(); vec_take_i = 1'b0;
        check("R5 gie cleared", 32'(core_q_o[7]), 32'h0);
        check("R5 irq low", 32'(irq_o), 32'h0);
        check("R7 flag kept", 32'(core_q_o[2]), 32'h1);
        check("R8 wake without gie", 32'(wake_o), 32'h1);
        reti_i = 1'b1; cyc(); reti_i = 1'b0;
        check("R6 gie set", 32'(core_q_o[7]), 32'h1);
        check("R7 re-entry", 32'(irq_o), 32'h1);
        vec_take_i = 1'b1; reti_i = 1'b1; cyc(); vec_take_i = 1'b0; reti_i = 1'b0;
        check("R6 take over reti", 32'(core_q_o[7]), 32'h0);
        reti_i = 1'b1; core_wr_i = 1'b1; core_wdata_i = 8'h27;
        cyc();
        reti_i = 1'b0; core_wr_i = 1'b0;
        check("R6 reti over write", 32'(core_q_o[7]), 32'h1);
        core_write(8'hA3);
        check("R9 write 0 clears", 32'(core_q_o[2]), 32'h0);

        // R9 event beats clear
        clear_all();
        tmr_ovf_i = 1'b1; core_wr_i = 1'b1; core_wdata_i = 8'h00;
        cyc();
        tmr_ovf_i = 1'b0; core_wr_i = 1'b0;
        check("R9 timer event wins", 32'(core_q_o[2]), 32'h1);
        per_evt_i = NP'(1) << 10; per_bank_i = 1'b1; per_flg_wr_i = 1'b1; per_wdata_i = 8'h00;
        cyc();
        per_evt_i = '0; per_flg_wr_i = 1'b0;
        check("R9 periph event wins", 32'(per_flag_o), 32'h0400);

        // R10 pin edge timing
        clear_all();
        ext_pin_i = 1'b1;
        cyc(); check("R10 edge+1", 32'(core_q_o[1]), 32'h0);
        cyc(); check("R10 edge+2", 32'(core_q_o[1]), 32'h0);
        cyc(); check("R10 edge+3", 32'(core_q_o[1]), 32'h1);
        core_write(8'h97);
        check("R4 pin irq without group", 32'(irq_o), 32'h1);
        core_write(8'h00);
        repeat (4) cyc();
        check("R10 held high no set", 32'(core_q_o[1]), 32'h0);
        ext_pin_i = 1'b0;
        repeat (5) cyc();
        check("R10 falling no set", 32'(core_q_o[1]), 32'h0);

        // R11 port change
        clear_all();
        port_i = 4'h5;
        cyc(); cyc();
        check("R11 change+2", 32'(core_q_o[0]), 32'h0);
        cyc();
        check("R11 change+3", 32'(core_q_o[0]), 32'h1);
        port_rd_i = 1'b1; cyc(); port_rd_i = 1'b0;
        core_write(8'h00);
        repeat (4) cyc();
        check("R11 snapshot matches", 32'(core_q_o[0]), 32'h0);
        port_i = 4'h3;
        repeat (3) cyc();
        check("R11 second change", 32'(core_q_o[0]), 32'h1);

        // R12 banks and R4 group gate
        clear_all();
        pen_write(1'b1, 8'hFF);
        check("R12 absent en bits", 32'(per_en_o), 32'h0F00);
        pen_write(1'b0, 8'hA5);
        check("R12 bank0 en", 32'(per_en_o), 32'h0FA5);
        per_evt_i = '1; cyc(); per_evt_i = '0;
        check("R12 all flags", 32'(per_flag_o), 32'h0FFF);
        pflg_write(1'b0, 8'hF0);
        check("R12 partial clear", 32'(per_flag_o), 32'h0FF0);
        core_write(8'h87);
        check("R4 group off irq", 32'(irq_o), 32'h0);
        check("R4 group off wake", 32'(wake_o), 32'h0);
        core_write(8'hC7);
        check("R4 group on irq", 32'(irq_o), 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule